// File: doc/BRIEF.md
# Sized Load/Store Unit over 16-bit Word Memory

This block serves loads and stores of 1, 2, 4 or 8 bytes for a 64-bit core whose data storage is an array of 16-bit words. A request carries a byte address, a size code given as a byte count, a direction, 64-bit write data and an extension mode for loads. The unit adds a segment base to the address and validates the request. It then reads or writes one word per clock until the access is complete and signals the end with a one-cycle done pulse. On a done pulse the unit reports either the load data or a fault cause.

Bytes within a word are selected by address parity. Wider accesses span consecutive words, with the lowest-indexed word holding the least significant bits, so the byte layout is little-endian throughout. Loads narrower than 64 bits are sign-extended unless the zero-extend mode is selected. The storage is local to the block. The memory start offset and the number of words are parameters, and they are expected to be a multiple of 8 and of 4 respectively.

Top module: `sized_lsu`

## Requirements
- R1: The effective address is `reqAddr` plus the zero-extended `segBase`, modulo 2^ADDR_W. The word index is (effective address − MEM_BASE) >> 1.
- R2: A request with a legal size whose effective address is below MEM_BASE, or whose word index is at or above MEM_WORDS, ends with fault code 1 (access). This check has priority over the alignment check.
- R3: A 2-, 4- or 8-byte request that passes the range check and whose effective address is not a multiple of its size ends with fault code 2 (alignment). A 1-byte request never raises this fault.
- R4: A size code other than 1, 2, 4 or 8 ends with fault code 3 (bad size), whatever the address is.
- R5: A faulted request writes nothing to memory. Its done pulse comes in the cycle after acceptance. Fault code 0 means success.
- R6: A 1-byte load at an even address returns bits 7:0 of the word. At an odd address it returns bits 15:8.
- R7: A 1-byte store replaces only the addressed byte of its word and leaves the other byte unchanged.
- R8: A 2-byte access uses one word, a 4-byte access uses two words and an 8-byte access uses four consecutive words. The least significant 16 bits are at the lowest word index.
- R9: With `reqZext` = 0, 1-, 2- and 4-byte loads are sign-extended from bit 7, 15 or 31 respectively. An 8-byte load is returned unchanged.
- R10: With `reqZext` = 1, loads of every size return the loaded field with all higher bits cleared.
- R11: A request is accepted on a clock edge where `reqValid` is 1 and `busy` is 0. A successful request of N word beats (N = 1, 1, 2, 4 for sizes 1, 2, 4, 8) gives a single-cycle `done` N+1 cycles after acceptance. `busy` stays high through the done cycle, and `reqValid` is ignored while `busy` is high.
- R12: During and after reset, `busy`, `done` and `fault` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe, taken when not busy |
| reqAddr | input | ADDR_W | Virtual byte address |
| reqSize | input | 4 | Access size in bytes (1, 2, 4 or 8) |
| reqWrite | input | 1 | 1 = store, 0 = load |
| reqZext | input | 1 | 1 = zero-extend loads, 0 = sign-extend |
| reqWdata | input | 64 | Store data, least significant bytes used |
| segBase | input | SEG_W | Data segment base added to the address |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 2 | Cause: 0 none, 1 access, 2 alignment, 3 bad size |
| rdata | output | 64 | Extended load data, valid with done on a successful load |

## Verification
The window is first filled with 8-byte stores. Every size is then loaded at every byte offset of a 24-byte window, in both extension modes and with two segment bases. This separates alignment faults from good loads, and it separates byte-lane and word-order errors and the sign versus zero fill. Stores of each size at each offset are followed by whole-word readbacks, which show partial-byte merging and show that faulted stores leave memory untouched. Directed requests straddle both range edges and combine bad sizes and misalignment with out-of-range addresses to fix the fault priority. A request is also raised while the unit is busy to show that it is ignored.

// File: rtl/sized_lsu_pkg.sv
package sized_lsu_pkg;

  typedef enum logic [1:0] {
    FLT_NONE   = 2'd0,
    FLT_ACCESS = 2'd1,
    FLT_ALIGN  = 2'd2,
    FLT_SIZE   = 2'd3
  } fault_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } state_e;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic       capture;
    logic       beat;
    logic [1:0] beatIdx;
  } strobe_t;

endpackage

// File: rtl/sized_lsu_mem.sv
module sized_lsu_mem #(
  parameter int unsigned WORDS = 64,
  localparam int unsigned IDX_W = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic [IDX_W-1:0] idx,
  input  logic             we,
  input  logic [15:0]      wdata,
  output logic [15:0]      rdata
);

  logic [15:0] cells [WORDS];

  assign rdata = cells[idx];

  always_ff @(posedge clk) begin
    if (we) cells[idx] <= wdata;
  end

endmodule

// File: rtl/sized_lsu_ctrl.sv
module sized_lsu_ctrl
  import sized_lsu_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  fault_e     checkFault,
  input  logic [1:0] lastBeat,
  output strobe_t    strobes,
  output logic       busy,
  output logic       done,
  output fault_e     faultQ
);

  state_e     state;
  logic [1:0] beatCnt;

  assign strobes.capture = (state == ST_IDLE) && reqValid;
  assign strobes.beat    = (state == ST_RUN);
  assign strobes.beatIdx = beatCnt;

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_FIN);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      beatCnt <= 2'd0;
      faultQ  <= FLT_NONE;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (reqValid) begin
            faultQ  <= checkFault;
            beatCnt <= 2'd0;
            state   <= (checkFault == FLT_NONE) ? ST_RUN : ST_FIN;
          end
        end
        ST_RUN: begin
          if (beatCnt == lastBeat) state <= ST_FIN;
          else beatCnt <= beatCnt + 2'd1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sized_lsu_dp.sv
module sized_lsu_dp
  import sized_lsu_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned SEG_W     = 16,
  parameter int unsigned MEM_BASE  = 256,
  parameter int unsigned MEM_WORDS = 64,
  localparam int unsigned IDX_W    = $clog2(MEM_WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [3:0]        reqSize,
  input  logic              reqWrite,
  input  logic              reqZext,
  input  logic [63:0]       reqWdata,
  input  logic [SEG_W-1:0]  segBase,
  input  strobe_t           strobes,
  output fault_e            checkFault,
  output logic [1:0]        lastBeat,
  output logic [IDX_W-1:0]  memIdx,
  output logic              memWe,
  output logic [15:0]       memWdata,
  input  logic [15:0]       memRdata,
  output logic [63:0]       rdata
);

  localparam logic [ADDR_W-1:0] BASE_A  = ADDR_W'(MEM_BASE);
  localparam logic [ADDR_W-1:0] WORDS_A = ADDR_W'(MEM_WORDS);

  // request decode, evaluated on the inputs while idle
  logic [ADDR_W-1:0] effAddr, offs, wordIdxFull;
  logic              sizeOk, outOfRange, misaligned;

  assign effAddr     = reqAddr + ADDR_W'(segBase);
  assign offs        = effAddr - BASE_A;
  assign wordIdxFull = {1'b0, offs[ADDR_W-1:1]};
  assign outOfRange  = (effAddr < BASE_A) || (wordIdxFull >= WORDS_A);

  always_comb begin
    sizeOk     = 1'b1;
    misaligned = 1'b0;
    unique case (reqSize)
      4'd1:    misaligned = 1'b0;
      4'd2:    misaligned = effAddr[0];
      4'd4:    misaligned = |effAddr[1:0];
      4'd8:    misaligned = |effAddr[2:0];
      default: sizeOk = 1'b0;
    endcase
  end

  always_comb begin
    if (!sizeOk)         checkFault = FLT_SIZE;
    else if (outOfRange) checkFault = FLT_ACCESS;
    else if (misaligned) checkFault = FLT_ALIGN;
    else                 checkFault = FLT_NONE;
  end

  // captured request
  logic [IDX_W-1:0] baseIdx;
  logic             laneHi, writeQ, zextQ;
  logic [3:0]       sizeQ;
  logic [63:0]      wdataQ, acc;

  always_comb begin
    unique case (sizeQ)
      4'd8:    lastBeat = 2'd3;
      4'd4:    lastBeat = 2'd1;
      default: lastBeat = 2'd0;
    endcase
  end

  assign memIdx = baseIdx + IDX_W'(strobes.beatIdx);
  assign memWe  = strobes.beat && writeQ;

  logic [15:0] beatSlice;
  assign beatSlice = wdataQ[{strobes.beatIdx, 4'b0000} +: 16];

  always_comb begin
    if (sizeQ == 4'd1)
      memWdata = laneHi ? {wdataQ[7:0], memRdata[7:0]}
                        : {memRdata[15:8], wdataQ[7:0]};
    else
      memWdata = beatSlice;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseIdx <= '0;
      laneHi  <= 1'b0;
      writeQ  <= 1'b0;
      zextQ   <= 1'b0;
      sizeQ   <= 4'd8;
      wdataQ  <= '0;
      acc     <= '0;
    end else if (strobes.capture) begin
      baseIdx <= offs[IDX_W:1];
      laneHi  <= effAddr[0];
      writeQ  <= reqWrite;
      zextQ   <= reqZext;
      sizeQ   <= reqSize;
      wdataQ  <= reqWdata;
      acc     <= '0;
    end else if (strobes.beat && !writeQ) begin
      if (sizeQ == 4'd1)
        acc[7:0] <= laneHi ? memRdata[15:8] : memRdata[7:0];
      else
        acc[{strobes.beatIdx, 4'b0000} +: 16] <= memRdata;
    end
  end

  // extension of the assembled field
  always_comb begin
    unique case (sizeQ)
      4'd1:    rdata = zextQ ? {56'd0, acc[7:0]}  : {{56{acc[7]}},  acc[7:0]};
      4'd2:    rdata = zextQ ? {48'd0, acc[15:0]} : {{48{acc[15]}}, acc[15:0]};
      4'd4:    rdata = zextQ ? {32'd0, acc[31:0]} : {{32{acc[31]}}, acc[31:0]};
      default: rdata = acc;
    endcase
  end

endmodule

// File: rtl/sized_lsu.sv
module sized_lsu
  import sized_lsu_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned SEG_W     = 16,
  parameter int unsigned MEM_BASE  = 256,
  parameter int unsigned MEM_WORDS = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [3:0]        reqSize,
  input  logic              reqWrite,
  input  logic              reqZext,
  input  logic [63:0]       reqWdata,
  input  logic [SEG_W-1:0]  segBase,
  output logic              busy,
  output logic              done,
  output logic [1:0]        fault,
  output logic [63:0]       rdata
);

  localparam int unsigned IDX_W = $clog2(MEM_WORDS);

  strobe_t          strobes;
  fault_e           checkFault, faultQ;
  logic [1:0]       lastBeat;
  logic [IDX_W-1:0] memIdx;
  logic             memWe;
  logic [15:0]      memWdata, memRdata;

  sized_lsu_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .checkFault (checkFault),
    .lastBeat   (lastBeat),
    .strobes    (strobes),
    .busy       (busy),
    .done       (done),
    .faultQ     (faultQ)
  );

  sized_lsu_dp #(
    .ADDR_W    (ADDR_W),
    .SEG_W     (SEG_W),
    .MEM_BASE  (MEM_BASE),
    .MEM_WORDS (MEM_WORDS)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .reqAddr    (reqAddr),
    .reqSize    (reqSize),
    .reqWrite   (reqWrite),
    .reqZext    (reqZext),
    .reqWdata   (reqWdata),
    .segBase    (segBase),
    .strobes    (strobes),
    .checkFault (checkFault),
    .lastBeat   (lastBeat),
    .memIdx     (memIdx),
    .memWe      (memWe),
    .memWdata   (memWdata),
    .memRdata   (memRdata),
    .rdata      (rdata)
  );

  sized_lsu_mem #(.WORDS(MEM_WORDS)) u_mem (
    .clk   (clk),
    .idx   (memIdx),
    .we    (memWe),
    .wdata (memWdata),
    .rdata (memRdata)
  );

  assign fault = faultQ;

endmodule

// File: rtl/sized_lsu_chk.sv
module sized_lsu_chk #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned SEG_W     = 16,
  parameter int unsigned MEM_BASE  = 256,
  parameter int unsigned MEM_WORDS = 64
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic [ADDR_W-1:0] reqAddr,
  input logic [3:0]        reqSize,
  input logic [SEG_W-1:0]  segBase,
  input logic              busy,
  input logic              done,
  input logic [1:0]        fault,
  input logic              memWe
);

  logic [ADDR_W-1:0] ea, rel;
  logic accept, legal, below, beyond, misal;

  assign ea     = reqAddr + ADDR_W'(segBase);
  assign rel    = ea - ADDR_W'(MEM_BASE);
  assign accept = reqValid && !busy;
  assign legal  = (reqSize == 4'd1) || (reqSize == 4'd2) || (reqSize == 4'd4) || (reqSize == 4'd8);
  assign below  = ea < ADDR_W'(MEM_BASE);
  assign beyond = (rel >> 1) >= ADDR_W'(MEM_WORDS);
  assign misal  = (reqSize == 4'd2 && ea[0]) || (reqSize == 4'd4 && |ea[1:0]) ||
                  (reqSize == 4'd8 && |ea[2:0]);

  a_r11_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r11_busy_with_done: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy);

  a_r11_hold_busy: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |=> busy);

  a_r4_bad_size: assert property (@(posedge clk) disable iff (!rstN)
    (accept && !legal) |=> (done && fault == 2'd3));

  a_r2_out_of_range: assert property (@(posedge clk) disable iff (!rstN)
    (accept && legal && (below || beyond)) |=> (done && fault == 2'd1));

  a_r3_misaligned: assert property (@(posedge clk) disable iff (!rstN)
    (accept && legal && !below && !beyond && misal) |=> (done && fault == 2'd2));

  a_r5_no_write_on_fault: assert property (@(posedge clk) disable iff (!rstN)
    (busy && fault != 2'd0) |-> !memWe);

endmodule

bind sized_lsu sized_lsu_chk #(
  .ADDR_W    (ADDR_W),
  .SEG_W     (SEG_W),
  .MEM_BASE  (MEM_BASE),
  .MEM_WORDS (MEM_WORDS)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .reqValid (reqValid),
  .reqAddr  (reqAddr),
  .reqSize  (reqSize),
  .segBase  (segBase),
  .busy     (busy),
  .done     (done),
  .fault    (fault),
  .memWe    (memWe)
);

// File: tb/sized_lsu_test.sv
module sized_lsu_test;

  localparam int BASE  = 256;
  localparam int WORDS = 64;
  localparam int NBYTE = 2 * WORDS;

  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid;
  logic [31:0] reqAddr;
  logic [3:0]  reqSize;
  logic        reqWrite;
  logic        reqZext;
  logic [63:0] reqWdata;
  logic [15:0] segBase;
  logic        busy, done;
  logic [1:0]  fault;
  logic [63:0] rdata;

  always #10 clk = ~clk;

  sized_lsu uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqSize(reqSize), .reqWrite(reqWrite), .reqZext(reqZext),
    .reqWdata(reqWdata), .segBase(segBase), .busy(busy), .done(done),
    .fault(fault), .rdata(rdata)
  );

  int checks = 0;
  int fails  = 0;
  logic [7:0] mdl [NBYTE];

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] expFault(input logic [31:0] addr, input logic [3:0] sz,
                                          input logic [15:0] seg);
    logic [31:0] ea;
    ea = addr + {16'd0, seg};
    if (!(sz == 1 || sz == 2 || sz == 4 || sz == 8)) return 2'd3;
    if (ea < BASE || ((ea - BASE) >> 1) >= WORDS) return 2'd1;
    if ((ea & ({28'd0, sz} - 32'd1)) != 0) return 2'd2;
    return 2'd0;
  endfunction

  function automatic logic [63:0] expLoad(input int off, input logic [3:0] sz, input bit zx);
    logic [63:0] raw;
    raw = '0;
    for (int i = 0; i < int'(sz); i++) raw[8*i +: 8] = mdl[off + i];
    if (zx || sz == 8) return raw;
    case (sz)
      4'd1:    return {{56{raw[7]}},  raw[7:0]};
      4'd2:    return {{48{raw[15]}}, raw[15:0]};
      default: return {{32{raw[31]}}, raw[31:0]};
    endcase
  endfunction

  function automatic logic [63:0] pat(input int k);
    logic [63:0] v;
    v = 64'h9E37_79B9_7F4A_7C15 * 64'(k + 3);
    return v ^ {v[31:0], v[63:32]};
  endfunction

  // issue one request and wait for its done pulse; sampled on falling edges
  task automatic access(input logic [31:0] addr, input logic [3:0] sz, input bit wr,
                        input bit zx, input logic [63:0] wd, input logic [15:0] seg,
                        input string dtag);
    logic [1:0]  ef, gotF;
    logic [63:0] gotD, ed;
    int lat, expLat, off;
    string ftag;
    ef  = expFault(addr, sz, seg);
    off = int'(addr + {16'd0, seg}) - BASE;
    reqAddr = addr; reqSize = sz; reqWrite = wr; reqZext = zx;
    reqWdata = wd; segBase = seg; reqValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    lat = 1;
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    gotD = rdata;
    gotF = fault;
    case (ef)
      2'd3:    ftag = "R4";
      2'd2:    ftag = "R3";
      2'd1:    ftag = "R2";
      default: ftag = "R1";
    endcase
    check(gotF == ef, ftag, 64'(gotF), 64'(ef));
    expLat = (ef != 0) ? 1 : (sz == 8) ? 5 : (sz == 4) ? 3 : 2;
    check(lat == expLat, (ef != 0) ? "R5" : "R11", 64'(lat), 64'(expLat));
    if (ef == 0 && !wr) begin
      ed = expLoad(off, sz, zx);
      check(gotD == ed, dtag != "" ? dtag : (zx ? "R10" : (sz == 8 ? "R8" : "R9")), gotD, ed);
    end
    if (ef == 0 && wr)
      for (int i = 0; i < int'(sz); i++) mdl[off + i] = wd[8*i +: 8];
    @(negedge clk);
    check(!done && !busy, "R11", {62'd0, done, busy}, 64'd0);
  endtask

  task automatic readWindow(input int startOff, input int nWords8, input string tag);
    for (int k = 0; k < nWords8; k++)
      access(32'(BASE + startOff + 8 * k), 4'd8, 1'b0, 1'b0, 64'd0, 16'd0, tag);
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [3:0] sizes [4];
    sizes[0] = 4'd1; sizes[1] = 4'd2; sizes[2] = 4'd4; sizes[3] = 4'd8;
    rstN = 1'b0; reqValid = 1'b0; reqAddr = '0; reqSize = 4'd1; reqWrite = 1'b0;
    reqZext = 1'b0; reqWdata = '0; segBase = '0;
    repeat (3) @(negedge clk);
    check(!busy && !done && fault == 0, "R12", {61'd0, busy, done, fault}, 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !done && fault == 0, "R12", {61'd0, busy, done, fault}, 64'd0);

    // fill the whole memory with 8-byte stores, then read back
    for (int k = 0; k < NBYTE / 8; k++)
      access(32'(BASE + 8 * k), 4'd8, 1'b1, 1'b0, pat(k), 16'd0, "");
    readWindow(0, NBYTE / 8, "R8");

    // load sweep: all sizes, offsets, modes, two segment bases
    for (int s = 0; s < 2; s++)
      for (int o = 0; o < 24; o++)
        for (int si = 0; si < 4; si++)
          for (int zx = 0; zx < 2; zx++) begin
            logic [15:0] seg;
            seg = (s == 0) ? 16'd0 : 16'h0030;
            access(32'(BASE + 40 + o) - {16'd0, seg}, sizes[si], 1'b0, zx[0],
                   64'd0, seg, "R1");
          end

    // store sweep: each size at each offset, then whole-word readback
    for (int si = 0; si < 4; si++)
      for (int o = 0; o < 8; o++) begin
        access(32'(BASE + 80 + o), sizes[si], 1'b1, 1'b0, pat(100 + 8 * si + o),
               16'd0, "");
        readWindow(80, 2, (si == 0) ? "R7" : "R5");
      end

    // byte lanes and byte merge
    access(32'(BASE + 1), 4'd1, 1'b1, 1'b0, 64'hFFFF_FFFF_FFFF_FFA5, 16'd0, "");
    access(32'(BASE + 0), 4'd2, 1'b0, 1'b1, 64'd0, 16'd0, "R7");
    access(32'(BASE + 0), 4'd1, 1'b0, 1'b1, 64'd0, 16'd0, "R6");
    access(32'(BASE + 1), 4'd1, 1'b0, 1'b1, 64'd0, 16'd0, "R6");
    access(32'(BASE + 6), 4'd1, 1'b1, 1'b0, 64'h3C, 16'd0, "");
    access(32'(BASE + 0), 4'd8, 1'b0, 1'b0, 64'd0, 16'd0, "R7");

    // sign and zero fill with boundary bit patterns
    access(32'(BASE + 16), 4'd8, 1'b1, 1'b0, 64'h8000_7F80_FF01_807F, 16'd0, "");
    access(32'(BASE + 16), 4'd1, 1'b0, 1'b0, 64'd0, 16'd0, "R9");
    access(32'(BASE + 17), 4'd1, 1'b0, 1'b0, 64'd0, 16'd0, "R9");
    access(32'(BASE + 18), 4'd2, 1'b0, 1'b0, 64'd0, 16'd0, "R9");
    access(32'(BASE + 20), 4'd4, 1'b0, 1'b0, 64'd0, 16'd0, "R9");
    access(32'(BASE + 20), 4'd4, 1'b0, 1'b1, 64'd0, 16'd0, "R10");
    access(32'(BASE + 17), 4'd1, 1'b0, 1'b1, 64'd0, 16'd0, "R10");
    access(32'(BASE + 16), 4'd8, 1'b0, 1'b0, 64'd0, 16'd0, "R8");

    // range edges and priorities
    access(32'(BASE - 1), 4'd1, 1'b0, 1'b0, 64'd0, 16'd0, "");
    access(32'(BASE - 8), 4'd8, 1'b1, 1'b0, 64'd1, 16'd0, "");
    access(32'(BASE + NBYTE - 1), 4'd1, 1'b0, 1'b0, 64'd0, 16'd0, "R1");
    access(32'(BASE + NBYTE), 4'd1, 1'b1, 1'b0, 64'd2, 16'd0, "");
    access(32'(BASE + NBYTE - 8), 4'd8, 1'b0, 1'b0, 64'd0, 16'h0008, "");
    access(32'(BASE - 3), 4'd4, 1'b0, 1'b0, 64'd0, 16'd0, "");
    access(32'(BASE + NBYTE + 1), 4'd2, 1'b0, 1'b0, 64'd0, 16'd0, "");
    access(32'(BASE - 1), 4'd3, 1'b0, 1'b0, 64'd0, 16'd0, "");
    access(32'(BASE + 3), 4'd1, 1'b0, 1'b0, 64'd0, 16'd0, "R6");

    // bad sizes on stores leave memory untouched
    foreach (sizes[i]) begin end
    for (int c = 0; c < 16; c++)
      if (!(c == 1 || c == 2 || c == 4 || c == 8))
        access(32'(BASE + 8), 4'(c), 1'b1, 1'b0, 64'hDEAD_BEEF_DEAD_BEEF, 16'd0, "");
    readWindow(0, 4, "R5");

    // a request raised while busy is ignored
    reqAddr = 32'(BASE + 24); reqSize = 4'd8; reqWrite = 1'b0; reqZext = 1'b0;
    segBase = 16'd0; reqValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reqAddr = 32'(BASE + 32); reqWrite = 1'b1; reqWdata = 64'h1111_2222_3333_4444;
    @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    repeat (6) @(negedge clk);
    check(!busy, "R11", {63'd0, busy}, 64'd0);
    readWindow(24, 2, "R11");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule